// File: doc/BRIEF.md
# Event-Scheduled DAC Update Controller

This block sits between a processor's byte-wide register bus and the input latch of a 10-bit current-output DAC. Software writes the next DAC code into two byte registers, high and low. The write does not reach the DAC at once. A hardware event copies the whole held word into the DAC latch in a single clock. The event can be an overflow pulse from one of four timers, or a chosen edge on an asynchronous convert-start pin. This keeps the sample timing of a generated waveform free of interrupt latency and instruction timing.

A control register holds a 3-bit trigger mode and a 2-bit full-scale range. The range goes straight to the analog current source, which is outside this block. Range 00 selects 0.5 mA, 01 selects 1 mA, and 1x selects 2 mA. The output current is code/1024 of the selected full scale. Mode 7 is a software-paced mode: the latch loads on the clock after a write to the high register, so software writes the low byte first and the high byte last.

Top module: `dac_update_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `dac_code` is 0, the high and low data registers are 0, the trigger mode is 0, and `fs_range` is 2'b10 (2 mA full scale).
- R2: Writes use `bus_addr` 0 for the high register, 1 for the low register and 2 for control. Control bits [2:0] hold the trigger mode and bits [5:4] hold the range. Reads at `bus_raddr` return the high byte, then {low[7:6], 6'b0}, then {2'b0, range, 1'b0, mode}. Address 3 reads 0. Low-register bits 5..0 are ignored and read as 0.
- R3: Modes 0 to 3 load the latch on the overflow pulse of timer 0 to 3 respectively. Pulses on the other timers have no effect.
- R4: Modes 4, 5 and 6 load on a rising, falling or either edge of `cnv_pin`. The pin goes through a two-flop synchronizer, so the latch changes on the third rising clock edge after the pin changes. Edges of the wrong polarity have no effect.
- R5: In mode 7 the latch loads on the clock edge after the edge that wrote the high register. A low-register write alone does not load it.
- R6: A register write never changes `dac_code` unless the selected event occurs.
- R7: If a write and an update event fall on the same clock edge, the latch takes the register contents from before that write. The new value waits for the next event.
- R8: On an event the latch takes {high[7:0], low[7:6]}, which is the left-justified 10-bit code.
- R9: `fs_range` follows control bits [5:4] from the clock edge that writes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one byte per cycle |
| bus_addr | input | 2 | Write address: 0 high, 1 low, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 2 | Read address |
| bus_rdata | output | 8 | Read data, combinational from `bus_raddr` |
| tmr_ovf | input | 4 | Timer overflow pulses, one bit per timer |
| cnv_pin | input | 1 | Asynchronous convert-start pin |
| dac_code | output | 10 | Latched DAC input code |
| fs_range | output | 2 | Full-scale range select for the current source |

## Verification
The embedded assertions assume that the timer overflow inputs are synchronous to `clk`, and that `cnv_pin` holds each level for at least two clocks so the synchronizer sees every edge. The stimulus changes all inputs only on falling clock edges. Each timer pulse is a single clock wide, and the pin holds each level for five clocks. A behavioural model in the bench keeps a queue of pin samples in place of the synchronizer. Each clock it compares the code, the range and the read data against the design, and scripted checks test the timing corners.

// File: rtl/dac_upd_pkg.sv
// Shared definitions for the scheduled DAC update controller.
// Assumes a byte-wide register bus with a 2-bit address.
package dac_upd_pkg;
    typedef enum logic [1:0] {
        ADDR_HI   = 2'd0,
        ADDR_LO   = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        TRIG_T0   = 3'd0,
        TRIG_T1   = 3'd1,
        TRIG_T2   = 3'd2,
        TRIG_T3   = 3'd3,
        TRIG_RISE = 3'd4,
        TRIG_FALL = 3'd5,
        TRIG_BOTH = 3'd6,
        TRIG_HIWR = 3'd7
    } trig_mode_e;

    localparam logic [1:0] RANGE_RESET = 2'b10;
endpackage

// File: rtl/dac_hold_regs.sv
// Holding registers: high and low data bytes and the control byte.
// Only the top LO_BITS bits of a low-register write are kept; the rest read as 0.
// Assumes one write per cycle and a synchronous active-low reset.
module dac_hold_regs
    import dac_upd_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int LO_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        raddr,
    output logic [DATA_W-1:0] hi_q,
    output logic [LO_BITS-1:0] lo_q,
    output trig_mode_e        mode_q,
    output logic [1:0]        range_q,
    output logic              hi_wr_q,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - LO_BITS;

    // Capture bus writes into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            mode_q  <= TRIG_T0;
            range_q <= RANGE_RESET;
        end else if (we) begin
            case (reg_addr_e'(addr))
                ADDR_HI:   hi_q <= wdata;
                ADDR_LO:   lo_q <= wdata[DATA_W-1 -: LO_BITS];
                ADDR_CTRL: begin
                    mode_q  <= trig_mode_e'(wdata[2:0]);
                    range_q <= wdata[5:4];
                end
                default: ;
            endcase
        end
    end

    // Remember a high-register write for the software-paced mode.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_wr_q <= 1'b0;
        else        hi_wr_q <= we && (reg_addr_e'(addr) == ADDR_HI);
    end

    // Read mux for software visibility of the held state.
    always_comb begin
        case (reg_addr_e'(raddr))
            ADDR_HI:   rdata = hi_q;
            ADDR_LO:   rdata = {lo_q, {PAD_W{1'b0}}};
            ADDR_CTRL: rdata = {2'b00, range_q, 1'b0, mode_q};
            default:   rdata = '0;
        endcase
    end

    // R2
    hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd0) |=> (rdata == hi_q || raddr != 2'd0) && hi_q == $past(wdata));
endmodule

// File: rtl/cnv_edge_sync.sv
// Synchronizes the asynchronous convert-start pin and makes one-clock
// rising and falling edge pulses from the synchronized level.
// Assumes the pin holds each level for at least STAGES clocks.
module cnv_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain;

    // Shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], pin};
    end

    // Compare the synchronized level with its previous value.
    always_comb begin
        rise = chain[STAGES-1] & ~chain[STAGES];
        fall = ~chain[STAGES-1] & chain[STAGES];
    end

    // R4
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise, fall}));
    // R4
    rise_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/dac_trig_sel.sv
// Chooses the update event named by the trigger mode.
// Assumes timer overflow pulses are synchronous to clk.
module dac_trig_sel
    import dac_upd_pkg::*;
#(
    parameter int N_TMR = 4
) (
    input  trig_mode_e       mode,
    input  logic [N_TMR-1:0] tmr_ovf,
    input  logic             rise,
    input  logic             fall,
    input  logic             hi_wr,
    output logic             trig
);
    localparam int SEL_W = $clog2(N_TMR);

    // Pick one event source per mode.
    always_comb begin
        case (mode)
            TRIG_RISE: trig = rise;
            TRIG_FALL: trig = fall;
            TRIG_BOTH: trig = rise | fall;
            TRIG_HIWR: trig = hi_wr;
            default:   trig = tmr_ovf[mode[SEL_W-1:0]];
        endcase
    end
endmodule

// File: rtl/dac_update_ctrl.sv
// Top of the scheduled DAC update controller. It holds the DAC code and
// loads it from the holding registers only on the selected hardware event.
// Assumes a synchronous active-low reset and inputs synchronous to clk,
// except cnv_pin, which is synchronized here.
module dac_update_ctrl
    import dac_upd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CODE_W = 10,
    parameter int N_TMR  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_TMR-1:0]  tmr_ovf,
    input  logic              cnv_pin,
    output logic [CODE_W-1:0] dac_code,
    output logic [1:0]        fs_range
);
    localparam int LO_BITS = CODE_W - DATA_W;

    logic [DATA_W-1:0]  hi_q;
    logic [LO_BITS-1:0] lo_q;
    trig_mode_e         mode_q;
    logic               hi_wr_q, rise, fall, trig;

    dac_hold_regs #(.DATA_W(DATA_W), .LO_BITS(LO_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .raddr(bus_raddr), .hi_q(hi_q), .lo_q(lo_q),
        .mode_q(mode_q), .range_q(fs_range), .hi_wr_q(hi_wr_q),
        .rdata(bus_rdata)
    );

    cnv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(cnv_pin), .rise(rise), .fall(fall)
    );

    dac_trig_sel #(.N_TMR(N_TMR)) u_sel (
        .mode(mode_q), .tmr_ovf(tmr_ovf), .rise(rise), .fall(fall),
        .hi_wr(hi_wr_q), .trig(trig)
    );

    // DAC input latch: copies the held word only on the event.
    always_ff @(posedge clk) begin
        if (!rst_n)    dac_code <= '0;
        else if (trig) dac_code <= {hi_q, lo_q};
    end

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> $stable(dac_code));
    // R8
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> dac_code == {$past(hi_q), $past(lo_q)});
endmodule

// File: tb/sim_dac_update_ctrl.sv
module sim_dac_update_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [1:0] bus_raddr = '0;
    logic [7:0] bus_rdata;
    logic [3:0] tmr_ovf = '0;
    logic       cnv_pin = 1'b0;
    logic [9:0] dac_code;
    logic [1:0] fs_range;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string phase = "R1";

    dac_update_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .tmr_ovf(tmr_ovf), .cnv_pin(cnv_pin), .dac_code(dac_code),
        .fs_range(fs_range)
    );

    always #5 clk = ~clk;

    // Behavioural reference model
    int m_hi, m_lo, m_mode, m_range, m_code;
    bit m_hiwr;
    bit pinq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_mode = 0; m_range = 2; m_code = 0; m_hiwr = 0;
            pinq = '{0, 0, 0};
        end else begin
            bit rs, fl, ev;
            rs = pinq[1] && !pinq[2];
            fl = !pinq[1] && pinq[2];
            case (m_mode)
                4: ev = rs;
                5: ev = fl;
                6: ev = rs || fl;
                7: ev = m_hiwr;
                default: ev = tmr_ovf[m_mode];
            endcase
            if (ev) m_code = m_hi * 4 + m_lo;
            m_hiwr = bus_we && bus_addr == 0;
            if (bus_we) begin
                if (bus_addr == 0) m_hi = bus_wdata;
                else if (bus_addr == 1) m_lo = bus_wdata / 64;
                else if (bus_addr == 2) begin
                    m_mode = bus_wdata % 8;
                    m_range = (bus_wdata / 16) % 4;
                end
            end
            pinq.push_front(cnv_pin);
            void'(pinq.pop_back());
        end
    end

    function automatic int exp_rd(int a);
        case (a)
            0: return m_hi;
            1: return m_lo * 64;
            2: return m_range * 16 + m_mode;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Compare with the model each cycle, away from the clock edges
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            chk({phase, " model code"}, int'(dac_code), m_code);
            chk({phase, " model range"}, int'(fs_range), m_range);
            chk({phase, " model rdata"}, int'(bus_rdata), exp_rd(int'(bus_raddr)));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a[1:0]; bus_wdata = d[7:0];
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pulse(int t);
        @(negedge clk);
        tmr_ovf[t] = 1'b1;
        @(negedge clk);
        tmr_ovf = '0;
    endtask

    task automatic rd(string tag, int a, int exp);
        bus_raddr = a[1:0];
        #1;
        chk(tag, int'(bus_rdata), exp);
    endtask

    initial begin
        tick(3);
        @(negedge clk) rst_n = 1'b1;
        #1;
        phase = "R1";
        chk("R1 code", int'(dac_code), 0);
        chk("R1 range", int'(fs_range), 2);
        rd("R1 ctrl read", 2, 8'h20);
        rd("R1 hi read", 0, 0);
        rd("R1 lo read", 1, 0);

        phase = "R9";
        wr(2, 8'h10);
        chk("R9 range 01", int'(fs_range), 1);

        phase = "R2";
        wr(0, 8'hC3);
        wr(1, 8'hFF);
        rd("R2 lo masked", 1, 8'hC0);
        rd("R2 hi read", 0, 8'hC3);
        rd("R2 ctrl read", 2, 8'h10);
        rd("R2 addr3 read", 3, 0);
        phase = "R6";
        chk("R6 held after writes", int'(dac_code), 0);

        phase = "R3";
        pulse(1);
        chk("R3 other timer ignored", int'(dac_code), 0);
        pulse(0);
        chk("R8 word mapping", int'(dac_code), 10'h30F);
        for (int m = 1; m < 4; m++) begin
            int h;
            h = m * 16 + 5;
            wr(2, 8'h20 + m);
            wr(0, h);
            pulse((m + 1) % 4);
            chk("R3 wrong timer", int'(dac_code), (m == 1) ? 10'h30F : ((h - 16) * 4 + 3));
            pulse(m);
            chk("R3 selected timer", int'(dac_code), h * 4 + 3);
        end

        phase = "R4";
        wr(2, 8'h24);
        wr(0, 8'h12);
        @(negedge clk) cnv_pin = 1'b1;
        tick(2);
        chk("R4 sync latency not yet", int'(dac_code), 10'h0D7);
        tick(1);
        chk("R4 rising edge load", int'(dac_code), 10'h04B);
        wr(0, 8'h34);
        @(negedge clk) cnv_pin = 1'b0;
        tick(5);
        chk("R4 falling ignored in rise mode", int'(dac_code), 10'h04B);
        wr(2, 8'h25);
        @(negedge clk) cnv_pin = 1'b1;
        tick(5);
        chk("R4 rising ignored in fall mode", int'(dac_code), 10'h04B);
        @(negedge clk) cnv_pin = 1'b0;
        tick(5);
        chk("R4 falling edge load", int'(dac_code), 10'h0D3);
        wr(2, 8'h26);
        wr(0, 8'h56);
        @(negedge clk) cnv_pin = 1'b1;
        tick(5);
        chk("R4 both, rising", int'(dac_code), 10'h15B);
        wr(0, 8'h78);
        @(negedge clk) cnv_pin = 1'b0;
        tick(5);
        chk("R4 both, falling", int'(dac_code), 10'h1E3);

        phase = "R5";
        wr(2, 8'h27);
        wr(1, 8'h40);
        tick(2);
        chk("R5 low write alone no load", int'(dac_code), 10'h1E3);
        wr(0, 8'h9A);
        chk("R5 not before next edge", int'(dac_code), 10'h1E3);
        tick(1);
        chk("R5 load after high write", int'(dac_code), 10'h269);

        phase = "R7";
        wr(2, 8'h20);
        pulse(0);
        @(negedge clk);
        tmr_ovf[0] = 1'b1; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 8'hFF;
        @(negedge clk);
        tmr_ovf = '0; bus_we = 1'b0;
        chk("R7 same-cycle takes old", int'(dac_code), 10'h269);
        pulse(0);
        chk("R7 new value on next event", int'(dac_code), 10'h3FD);

        phase = "R9";
        wr(2, 8'h30);
        chk("R9 range 11", int'(fs_range), 3);
        wr(2, 8'h00);
        chk("R9 range 00", int'(fs_range), 0);
        tick(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule